// File: doc/BRIEF.md
# Exception Entry Sequencer

This block is the piece of a processor core that carries out entry into an exception handler. Each idle cycle it looks at three request sources: a software break trap, a memory-management fault and an interrupt line from an external interrupt controller. It picks one of them, together with that source's vector number. It then drives the exception return address, reads the handler address from a vector table in memory, and hands the core a new program counter and a new status word.

The table holds one 32-bit word per vector, starting at the table base register. The read goes through a simple port that allows one outstanding read. The port keeps a request level high until the memory answers with a single valid pulse. While an entry is in progress the block reports busy and does not look at new requests.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `busy`, `rd_req`, `erp_we`, `pc_we` and `status_we` are low.
- R2: The block accepts a request at a clock edge. In the following cycle `rd_req` is high and `rd_addr` equals `tbl_base + 4*vector`. `rd_req` stays high, with `rd_addr` unchanged, until the clock edge at which `rd_valid` is seen high.
- R3: When a break trap is taken, the vector is `brk_vec`. `erp_we` pulses for exactly one cycle, the cycle after acceptance, with `erp_val = cur_pc + 2`.
- R4: When a fault is taken, the vector is `mmu_vec`, and `erp_we` stays low for the whole entry, because the return address comes from elsewhere.
- R5: When an interrupt is taken, the vector is `irq_vec`, and `erp_we` pulses for one cycle with `erp_val = cur_pc`.
- R6: An interrupt request whose `irq_vec` is below 0x30 is ignored: `busy` and `rd_req` stay low.
- R7: An interrupt request is ignored while the interrupt-enable bit of `status_in` (bit 8) is clear.
- R8: When requests arrive together, the break trap wins over the fault, and the fault wins over the interrupt.
- R9: One cycle after `rd_valid` is seen during a fetch, `pc_we` is high for exactly one cycle and `pc_val` equals the `rd_data` word that came with that `rd_valid`.
- R10: In the same cycle as `pc_we`, `status_we` is high and `status_val = (S & 0xC000_0000) | (((S << 12) mod 2^32) >> 2)`, where S is the `status_in` value sampled at acceptance.
- R11: `busy` is high from the cycle after acceptance through the cycle in which `pc_we` is high, and falls in the next cycle. Requests present while `busy` is high start nothing: `rd_addr` does not change and `erp_we` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| brk_req | input | 1 | Software break trap request |
| brk_vec | input | 8 | Vector for the break trap |
| mmu_req | input | 1 | Memory-management fault request |
| mmu_vec | input | 8 | Vector for the fault |
| irq_req | input | 1 | Interrupt request from the controller |
| irq_vec | input | 8 | Vector supplied by the interrupt controller |
| cur_pc | input | 32 | Current program counter |
| status_in | input | 32 | Current status word |
| tbl_base | input | 32 | Vector table base address |
| rd_req | output | 1 | Table read request, held until answered |
| rd_addr | output | 32 | Table read address |
| rd_valid | input | 1 | Read data valid, one pulse per request |
| rd_data | input | 32 | Read data word |
| busy | output | 1 | Entry in progress |
| erp_we | output | 1 | Return address write strobe |
| erp_val | output | 32 | Return address value |
| pc_we | output | 1 | Program counter write strobe |
| pc_val | output | 32 | Handler address for the program counter |
| status_we | output | 1 | Status word write strobe |
| status_val | output | 32 | Rewritten status word |

## Verification
The properties assume that the memory raises `rd_valid` only while `rd_req` is high, and at most once per request. The bench memory model meets this by answering each read once, after a random delay of zero to three cycles. The properties also assume that the request and operand inputs are stable during the cycle in which they are sampled. The bench changes every input only on falling edges, and it drops request lines as soon as an entry has been accepted. The only exception is a deliberate request raised while the block is busy, which is withdrawn before the read completes.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_BRK  = 2'd1,
    CAUSE_MMU  = 2'd2,
    CAUSE_IRQ  = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOAD  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/exc_req_select.sv
module exc_req_select
  import exc_entry_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int XLEN    = 32,
  parameter int IRQ_MIN = 'h30,
  parameter int IE_BIT  = 8
) (
  input  logic             brk_req,
  input  logic [VEC_W-1:0] brk_vec,
  input  logic             mmu_req,
  input  logic [VEC_W-1:0] mmu_vec,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  status_in,
  output logic             sel_valid,
  output cause_e           sel_cause,
  output logic [VEC_W-1:0] sel_vec,
  output logic             sel_erp_we,
  output logic [XLEN-1:0]  sel_erp
);
  localparam logic [VEC_W-1:0] IRQ_FLOOR = VEC_W'(IRQ_MIN);

  logic irq_ok;
  assign irq_ok = irq_req && (irq_vec >= IRQ_FLOOR) && status_in[IE_BIT];

  always_comb begin
    sel_cause  = CAUSE_NONE;
    sel_vec    = '0;
    sel_erp_we = 1'b0;
    sel_erp    = cur_pc;
    if (brk_req) begin
      sel_cause  = CAUSE_BRK;
      sel_vec    = brk_vec;
      sel_erp_we = 1'b1;
      sel_erp    = cur_pc + XLEN'(2);
    end else if (mmu_req) begin
      sel_cause  = CAUSE_MMU;
      sel_vec    = mmu_vec;
    end else if (irq_ok) begin
      sel_cause  = CAUSE_IRQ;
      sel_vec    = irq_vec;
      sel_erp_we = 1'b1;
    end
  end

  assign sel_valid = (sel_cause != CAUSE_NONE);
endmodule

// File: rtl/exc_status_shift.sv
module exc_status_shift #(
  parameter int XLEN  = 32,
  parameter int KEEP  = 2,
  parameter int SHL   = 12,
  parameter int SHR   = 2
) (
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);
  localparam logic [XLEN-1:0] KEEP_MASK = {{KEEP{1'b1}}, {(XLEN-KEEP){1'b0}}};

  logic [XLEN-1:0] up;
  assign up = d << SHL;
  assign q  = (d & KEEP_MASK) | (up >> SHR);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int XLEN    = 32,
  parameter int IRQ_MIN = 'h30,
  parameter int IE_BIT  = 8,
  parameter int KEEP    = 2,
  parameter int SHL     = 12,
  parameter int SHR     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             brk_req,
  input  logic [VEC_W-1:0] brk_vec,
  input  logic             mmu_req,
  input  logic [VEC_W-1:0] mmu_vec,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  status_in,
  input  logic [XLEN-1:0]  tbl_base,
  output logic             rd_req,
  output logic [XLEN-1:0]  rd_addr,
  input  logic             rd_valid,
  input  logic [XLEN-1:0]  rd_data,
  output logic             busy,
  output logic             erp_we,
  output logic [XLEN-1:0]  erp_val,
  output logic             pc_we,
  output logic [XLEN-1:0]  pc_val,
  output logic             status_we,
  output logic [XLEN-1:0]  status_val
);
  localparam int PAD_W = XLEN - VEC_W - 2;

  seq_state_e       state;
  logic             sel_valid;
  cause_e           sel_cause;
  logic [VEC_W-1:0] sel_vec;
  logic             sel_erp_we;
  logic [XLEN-1:0]  sel_erp;
  logic [XLEN-1:0]  st_shifted;
  logic [XLEN-1:0]  st_hold;
  logic [XLEN-1:0]  tbl_offs;

  exc_req_select #(
    .VEC_W(VEC_W), .XLEN(XLEN), .IRQ_MIN(IRQ_MIN), .IE_BIT(IE_BIT)
  ) u_sel (
    .brk_req(brk_req), .brk_vec(brk_vec),
    .mmu_req(mmu_req), .mmu_vec(mmu_vec),
    .irq_req(irq_req), .irq_vec(irq_vec),
    .cur_pc(cur_pc), .status_in(status_in),
    .sel_valid(sel_valid), .sel_cause(sel_cause), .sel_vec(sel_vec),
    .sel_erp_we(sel_erp_we), .sel_erp(sel_erp)
  );

  exc_status_shift #(
    .XLEN(XLEN), .KEEP(KEEP), .SHL(SHL), .SHR(SHR)
  ) u_shift (
    .d(status_in),
    .q(st_shifted)
  );

  // word-indexed table: vector times four
  assign tbl_offs = {{PAD_W{1'b0}}, sel_vec, 2'b00};
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      erp_we     <= 1'b0;
      erp_val    <= '0;
      pc_we      <= 1'b0;
      pc_val     <= '0;
      status_we  <= 1'b0;
      status_val <= '0;
      st_hold    <= '0;
    end else begin
      erp_we    <= 1'b0;
      pc_we     <= 1'b0;
      status_we <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (sel_valid && (sel_cause != CAUSE_NONE)) begin
            state   <= ST_FETCH;
            rd_req  <= 1'b1;
            rd_addr <= tbl_base + tbl_offs;
            erp_we  <= sel_erp_we;
            if (sel_erp_we) erp_val <= sel_erp;
            st_hold <= st_shifted;
          end
        end
        ST_FETCH: begin
          if (rd_valid) begin
            state      <= ST_LOAD;
            rd_req     <= 1'b0;
            pc_we      <= 1'b1;
            pc_val     <= rd_data;
            status_we  <= 1'b1;
            status_val <= st_hold;
          end
        end
        ST_LOAD: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int VEC_W   = 8,
  parameter int XLEN    = 32,
  parameter int IRQ_MIN = 'h30,
  parameter int IE_BIT  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             brk_req,
  input logic [VEC_W-1:0] brk_vec,
  input logic             mmu_req,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic [XLEN-1:0]  cur_pc,
  input logic [XLEN-1:0]  status_in,
  input logic [XLEN-1:0]  tbl_base,
  input logic             rd_req,
  input logic [XLEN-1:0]  rd_addr,
  input logic             rd_valid,
  input logic [XLEN-1:0]  rd_data,
  input logic             busy,
  input logic             erp_we,
  input logic [XLEN-1:0]  erp_val,
  input logic             pc_we,
  input logic [XLEN-1:0]  pc_val,
  input logic             status_we
);
  localparam logic [VEC_W-1:0] IRQ_FLOOR = VEC_W'(IRQ_MIN);

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!busy && !rd_req && !erp_we && !pc_we && !status_we));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  // R2
  brk_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && brk_req) |=>
      (rd_addr == $past(tbl_base) + {{(XLEN-VEC_W-2){1'b0}}, $past(brk_vec), 2'b00}));

  // R3
  brk_erp_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && brk_req) |=> (erp_we && erp_val == $past(cur_pc) + XLEN'(2)));

  // R4
  mmu_no_erp_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !brk_req && mmu_req) |=> (rd_req && !erp_we));

  // R6
  irq_low_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !brk_req && !mmu_req && irq_req && irq_vec < IRQ_FLOOR) |=> !busy);

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !brk_req && !mmu_req && !status_in[IE_BIT]) |=> !busy);

  // R9
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_valid) |=> (pc_we && status_we && pc_val == $past(rd_data)));

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    pc_we |=> (!pc_we && !busy));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_req) |=> (!rd_req && !erp_we));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .VEC_W(VEC_W), .XLEN(XLEN), .IRQ_MIN(IRQ_MIN), .IE_BIT(IE_BIT)
) u_chk (
  .clk(clk), .rst(rst),
  .brk_req(brk_req), .brk_vec(brk_vec), .mmu_req(mmu_req),
  .irq_req(irq_req), .irq_vec(irq_vec),
  .cur_pc(cur_pc), .status_in(status_in), .tbl_base(tbl_base),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
  .busy(busy), .erp_we(erp_we), .erp_val(erp_val),
  .pc_we(pc_we), .pc_val(pc_val), .status_we(status_we)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        brk_req = 0, mmu_req = 0, irq_req = 0;
  logic [7:0]  brk_vec = 0, mmu_vec = 0, irq_vec = 0;
  logic [31:0] cur_pc = 0, status_in = 0, tbl_base = 0;
  logic        rd_valid = 0;
  logic [31:0] rd_data = 0;
  logic        rd_req, busy, erp_we, pc_we, status_we;
  logic [31:0] rd_addr, erp_val, pc_val, status_val;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst(rst),
    .brk_req(brk_req), .brk_vec(brk_vec),
    .mmu_req(mmu_req), .mmu_vec(mmu_vec),
    .irq_req(irq_req), .irq_vec(irq_vec),
    .cur_pc(cur_pc), .status_in(status_in), .tbl_base(tbl_base),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .erp_we(erp_we), .erp_val(erp_val),
    .pc_we(pc_we), .pc_val(pc_val),
    .status_we(status_we), .status_val(status_val)
  );

  function automatic logic [31:0] exp_status(input logic [31:0] s);
    logic [31:0] t;
    t = s << 12;
    return (s & 32'hC000_0000) | (t >> 2);
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One entry attempt; inputs change on falling edges only.
  task automatic attempt(input logic b, input logic [7:0] bv,
                         input logic m, input logic [7:0] mv,
                         input logic i, input logic [7:0] iv,
                         input logic [31:0] pc, input logic [31:0] st,
                         input logic [31:0] base, input int lat,
                         input logic poke);
    logic        acc, wr_erp;
    logic [7:0]  v;
    logic [31:0] ea, ex_addr;
    acc = 1'b0; wr_erp = 1'b0; v = 0; ea = 0;
    if (b) begin acc = 1; v = bv; wr_erp = 1; ea = pc + 2; end
    else if (m) begin acc = 1; v = mv; end
    else if (i && iv >= 8'h30 && st[8]) begin acc = 1; v = iv; wr_erp = 1; ea = pc; end
    ex_addr = base + {22'd0, v, 2'b00};

    brk_req = b; brk_vec = bv; mmu_req = m; mmu_vec = mv;
    irq_req = i; irq_vec = iv; cur_pc = pc; status_in = st; tbl_base = base;
    @(negedge clk);
    brk_req = 0; mmu_req = 0; irq_req = 0;
    status_in = ~st;
    if (!acc) begin
      chk(!busy && !rd_req && !erp_we, "R6/R7 ignored request", {29'd0, busy, rd_req, erp_we}, 0);
      return;
    end
    chk(busy && rd_req, "R2/R11 fetch started", {30'd0, busy, rd_req}, 2'b11);
    chk(rd_addr == ex_addr, b ? "R2 R3 brk table address" : (m ? "R2 R4 mmu table address" : "R2 R5 irq table address"), rd_addr, ex_addr);
    chk(erp_we == wr_erp, b ? "R3 erp strobe" : (m ? "R4 no erp on fault" : "R5 erp strobe"), {31'd0, erp_we}, {31'd0, wr_erp});
    if (wr_erp) chk(erp_val == ea, b ? "R3 erp value" : "R5 erp value", erp_val, ea);
    for (int k = 0; k < lat; k++) begin
      if (poke && k == 0) begin brk_req = 1; brk_vec = bv ^ 8'h5A; end
      @(negedge clk);
      brk_req = 0;
      chk(rd_req && rd_addr == ex_addr && !erp_we && !pc_we, "R2/R11 hold while waiting", rd_addr, ex_addr);
    end
    rd_valid = 1; rd_data = mem_word(ex_addr);
    @(negedge clk);
    rd_valid = 0;
    chk(pc_we && pc_val == mem_word(ex_addr), "R9 pc load", pc_val, mem_word(ex_addr));
    chk(status_we && status_val == exp_status(st), "R10 status rewrite", status_val, exp_status(st));
    chk(busy && !rd_req, "R11 busy through load", {30'd0, busy, rd_req}, 2'b10);
    @(negedge clk);
    chk(!busy && !pc_we && !status_we, "R11 busy falls, R9 single pulse", {29'd0, busy, pc_we, status_we}, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !erp_we && !pc_we && !status_we, "R1 in reset", {27'd0, busy, rd_req, erp_we, pc_we, status_we}, 0);
    rst = 0;
    @(negedge clk);
    chk(!busy && !rd_req && !erp_we && !pc_we && !status_we, "R1 after reset", {27'd0, busy, rd_req, erp_we, pc_we, status_we}, 0);

    // directed corners
    attempt(1, 8'h07, 0, 0, 0, 0, 32'h1000_0000, 32'h0000_0100, 32'h8000_0000, 0, 0); // R3
    attempt(0, 0, 1, 8'h04, 0, 0, 32'h2000_0040, 32'hFFFF_FFFF, 32'h4000_0000, 2, 0); // R4
    attempt(0, 0, 0, 0, 1, 8'h30, 32'h3000_0010, 32'hC000_0100, 32'h0000_1000, 1, 0); // R5 boundary
    attempt(0, 0, 0, 0, 1, 8'h2F, 32'h3000_0010, 32'h0000_0100, 32'h0000_1000, 1, 0); // R6
    attempt(0, 0, 0, 0, 1, 8'h45, 32'h3000_0010, 32'hFFFF_FEFF, 32'h0000_1000, 1, 0); // R7
    attempt(1, 8'h11, 1, 8'h22, 1, 8'h33, 32'h0000_0100, 32'h0000_0100, 32'h0001_0000, 0, 0); // R8
    attempt(0, 0, 1, 8'h22, 1, 8'h33, 32'h0000_0100, 32'h0000_0100, 32'h0001_0000, 0, 0); // R8
    attempt(0, 0, 0, 0, 1, 8'hFF, 32'hFFFF_FFFE, 32'h8003_F5A1, 32'hFFFF_FC00, 3, 1); // R11 poke
    attempt(1, 8'h00, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0, 3, 1); // R3 wrap

    // random
    for (int n = 0; n < 60; n++) begin
      logic [31:0] r;
      r = $urandom;
      attempt(r[0] & r[1], 8'($urandom), r[2] & r[3], 8'($urandom), r[4],
              8'($urandom), $urandom, $urandom, $urandom & 32'hFFFF_FF00,
              int'(r[9:8]), r[10]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule